// File: doc/BRIEF.md
# Host Processor Bus Bridge

This block connects an external, non-multiplexed, asynchronous host bus to the core clock domain of a switching chip. The host drives a 14-bit address, a 16-bit write word, a chip select and two shared control lines. The meaning of the two control lines is set by a strap input. In one style the lines are a data strobe and a read/write direction line. In the other they are a separate read strobe and a separate write strobe. The chip select and both control lines pass through two-flop synchronisers. A new access begins on the clock where the synchronised strobe becomes active.

Each access is decoded into one of four targets: a bank of control registers inside the bridge, the connection memory, the data memory, or an unmapped hole. Memory accesses go out on a valid/ready request channel. The memory returns read data on a one-way response strobe. The bridge raises `data_rdy` once a read word is on `rdata` or a write has been committed. It holds `data_rdy` until the host releases the strobe.

For a fixed number of core cycles after reset is released, the bridge locks out host accesses. Strobes in that window are ignored and get no acknowledge.

Request channel rules: `mem_req_valid` is raised with the address, select, direction and write word already set. All of them stay unchanged until the core samples `mem_req_ready` high on a rising edge. Only one request is outstanding at a time. For a read, the memory pulses `mem_rsp_valid` for one cycle with the word, some time after it accepted the request. The bridge always takes the response and has no ready line for it.

Top module: `host_port_bridge`

## Requirements
- R1: With `bus_mode` high, an access starts when `cs_n` and `strb_rd_n` are both low. `dir_wr_n` high selects a read and `dir_wr_n` low selects a write.
- R2: With `bus_mode` low, an access starts when `cs_n` is low and either strobe is low. `strb_rd_n` low is a read and `dir_wr_n` low is a write.
- R3: Count edge 1 as the first rising edge that samples the strobe active. Let W be the number of cycles `mem_req_ready` stays low. `data_rdy` is high after edge 4 for a control-register or unmapped access, after edge 5+W for a memory write, and after edge 6+W for a memory read. It is never high otherwise.
- R4: `data_rdy` stays high while the strobe is held. It falls after the third rising edge that samples the strobe released. A further access needs a new strobe activation.
- R5: Address bits [13:12] select the target: 00 control registers, 01 unmapped, 10 connection memory (`mem_req_sel`=0), 11 data memory (`mem_req_sel`=1). Bits [11:0] form `mem_req_addr`.
- R6: In region 00, an index at or above NREG (default 8) is unmapped. Unmapped reads return 0 and unmapped writes change nothing. Both are still acknowledged.
- R7: After reset, control register i reads DEF_BASE+i (default 16'h5A00+i). A write replaces the whole word.
- R8: For LOCK_CYC cycles after reset is released, no access is started and `data_rdy` stays low. A strobe that is already active when the window ends is also ignored.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request fields stay stable. A memory write is committed when the request is accepted.
- R10: A memory read places the `mem_rsp_data` word on `rdata` in the same cycle that `data_rdy` rises.
- R11: Reset clears `data_rdy`, reloads the control-register defaults and restarts the lockout window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_mode | input | 1 | Strap: 1 = strobe plus direction, 0 = separate read/write strobes |
| cs_n | input | 1 | Active-low chip select |
| strb_rd_n | input | 1 | Data strobe (mode 1) or read strobe (mode 0), active low |
| dir_wr_n | input | 1 | Direction, low = write (mode 1), or write strobe (mode 0) |
| addr | input | 14 | Host address |
| wdata | input | 16 | Host write word |
| rdata | output | 16 | Read word returned to the host |
| data_rdy | output | 1 | Access acknowledge |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | Request is a write |
| mem_req_sel | output | 1 | 0 = connection memory, 1 = data memory |
| mem_req_addr | output | 12 | Memory word address |
| mem_req_wdata | output | 16 | Memory write word |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | 16 | Read response word |

## Verification
The synchroniser adds two edges of delay and the edge detector one more. Therefore `data_rdy` is due exactly 4, 5+W or 6+W edges after the strobe is first sampled, and it drops 3 edges after release. The bench model counts these edges on its own copy of the pin history and compares `data_rdy` on every falling edge. It also compares `rdata` whenever a read is acknowledged. The memory stand-in holds `mem_req_ready` low for a chosen number of cycles, so W varies between accesses, and the request fields are compared on the cycle they are accepted.

// File: rtl/hpb_pkg.sv
package hpb_pkg;

  // target of one host access, from the top address bits
  typedef enum logic [1:0] {
    TGT_CTRL = 2'd0,
    TGT_NONE = 2'd1,
    TGT_CONN = 2'd2,
    TGT_DMEM = 2'd3
  } tgt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXEC,
    ST_REQ,
    ST_RSP,
    ST_ACK
  } st_e;

endpackage

// File: rtl/hpb_sync.sv
module hpb_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stab;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= RST_VAL[i];
        stab <= RST_VAL[i];
      end else begin
        meta <= d[i];
        stab <= meta;
      end
    end
    assign q[i] = stab;
  end

endmodule

// File: rtl/hpb_decode.sv
module hpb_decode
  import hpb_pkg::*;
#(
  parameter int AW   = 14,
  parameter int NREG = 8,
  localparam int OW  = AW - 2
) (
  input  logic [AW-1:0] addr,
  output tgt_e          tgt,
  output logic [OW-1:0] off
);

  assign off = addr[OW-1:0];

  always_comb begin
    unique case (addr[AW-1:AW-2])
      2'b00:   tgt = (off < OW'(NREG)) ? TGT_CTRL : TGT_NONE;
      2'b01:   tgt = TGT_NONE;
      2'b10:   tgt = TGT_CONN;
      default: tgt = TGT_DMEM;
    endcase
  end

endmodule

// File: rtl/hpb_ctrl_regs.sv
module hpb_ctrl_regs #(
  parameter int            DW       = 16,
  parameter int            NREG     = 8,
  parameter logic [DW-1:0] DEF_BASE = 'h5A00,
  localparam int           IW       = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            bank[g] <= DEF_BASE + DW'(g);
      else if (wr_en && idx == IW'(g))       bank[g] <= wr_data;
    end

    // R7: a write to this entry lands on the next edge
    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == IW'(g)) |=> bank[g] == $past(wr_data));
  end

  assign rd_data = bank[idx];

endmodule

// File: rtl/host_port_bridge.sv
module host_port_bridge
  import hpb_pkg::*;
#(
  parameter int            AW       = 14,
  parameter int            DW       = 16,
  parameter int            NREG     = 8,
  parameter logic [DW-1:0] DEF_BASE = 'h5A00,
  parameter int            LOCK_CYC = 25000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_mode,
  input  logic          cs_n,
  input  logic          strb_rd_n,
  input  logic          dir_wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          data_rdy,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic          mem_req_sel,
  output logic [AW-3:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);

  localparam int OW = AW - 2;
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int LW = $clog2(LOCK_CYC + 1);

  // ---- strobe synchronisation and edge detection ----
  logic [2:0] pin_s;
  logic       cs_s, strb_s, dir_s;
  logic       act, act_d, is_wr;

  hpb_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cs_n, strb_rd_n, dir_wr_n}),
    .q    (pin_s)
  );

  assign {cs_s, strb_s, dir_s} = pin_s;
  assign act   = bus_mode ? (!cs_s && !strb_s) : (!cs_s && (!strb_s || !dir_s));
  assign is_wr = !dir_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_d <= 1'b0;
    else        act_d <= act;
  end

  // ---- post-reset lockout ----
  logic [LW-1:0] lock_cnt;
  logic          locked;

  assign locked = lock_cnt < LW'(LOCK_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lock_cnt <= '0;
    else if (locked) lock_cnt <= lock_cnt + 1'b1;
  end

  // ---- decode and control registers ----
  tgt_e          dec_tgt, tgt_q;
  logic [OW-1:0] dec_off, off_q;
  logic          we_q;
  logic [DW-1:0] wd_q, rd_q, reg_rd;
  st_e           st;
  logic          start, reg_we;

  hpb_decode #(.AW(AW), .NREG(NREG)) u_dec (
    .addr(addr),
    .tgt (dec_tgt),
    .off (dec_off)
  );

  assign reg_we = (st == ST_EXEC) && (tgt_q == TGT_CTRL) && we_q;

  hpb_ctrl_regs #(.DW(DW), .NREG(NREG), .DEF_BASE(DEF_BASE)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_we),
    .idx    (off_q[IW-1:0]),
    .wr_data(wd_q),
    .rd_data(reg_rd)
  );

  // ---- access sequencer ----
  assign start = (st == ST_IDLE) && act && !act_d && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      tgt_q <= TGT_NONE;
      off_q <= '0;
      we_q  <= 1'b0;
      wd_q  <= '0;
      rd_q  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          st    <= ST_EXEC;
          tgt_q <= dec_tgt;
          off_q <= dec_off;
          we_q  <= is_wr;
          wd_q  <= wdata;
        end
        ST_EXEC: begin
          if (tgt_q == TGT_CONN || tgt_q == TGT_DMEM) begin
            st <= ST_REQ;
          end else begin
            st <= ST_ACK;
            if (!we_q) rd_q <= (tgt_q == TGT_CTRL) ? reg_rd : '0;
          end
        end
        ST_REQ: if (mem_req_ready) st <= we_q ? ST_ACK : ST_RSP;
        ST_RSP: if (mem_rsp_valid) begin
          rd_q <= mem_rsp_data;
          st   <= ST_ACK;
        end
        ST_ACK: if (!act) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign data_rdy      = (st == ST_ACK);
  assign rdata         = rd_q;
  assign mem_req_valid = (st == ST_REQ);
  assign mem_req_we    = we_q;
  assign mem_req_sel   = (tgt_q == TGT_DMEM);
  assign mem_req_addr  = off_q;
  assign mem_req_wdata = wd_q;

  // ---- checks ----
  // R9: a stalled request keeps its fields
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_sel) && $stable(mem_req_wdata)));

  // R8: no acknowledge inside the lockout window
  a_r8_locked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !data_rdy);

  // R4: released strobe ends the acknowledge on the next edge
  a_r4_release_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rdy && !act) |=> !data_rdy);

  // R6: unmapped reads give zero
  a_r6_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rdy && tgt_q == TGT_NONE && !we_q) |-> rdata == '0);

  // R10: the response word is presented with the acknowledge
  a_r10_rsp_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RSP && mem_rsp_valid) |=> (data_rdy && rdata == $past(mem_rsp_data)));

endmodule

// File: tb/host_port_bridge_bench.sv
module host_port_bridge_bench;

  localparam int LOCK = 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_mode, cs_n, strb_rd_n, dir_wr_n;
  logic [13:0] addr;
  logic [15:0] wdata, rdata;
  logic        data_rdy;
  logic        mem_req_valid, mem_req_ready, mem_req_we, mem_req_sel;
  logic [11:0] mem_req_addr;
  logic [15:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [15:0] mem_rsp_data;

  always #10 clk = ~clk;

  host_port_bridge #(.LOCK_CYC(LOCK)) u_host_port_bridge (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n),
    .strb_rd_n(strb_rd_n), .dir_wr_n(dir_wr_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .data_rdy(data_rdy), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we), .mem_req_sel(mem_req_sel),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", what, got, exp);
    end
  endtask

  // ---- current access, set by the driving task ----
  int          cur_stall = 0;
  bit          cur_we    = 0;
  logic [13:0] cur_addr  = '0;
  logic [15:0] cur_wdata = '0;

  // ---- memory stand-in ----
  logic [15:0] bmem [128];
  int          vcnt;

  assign mem_req_ready = mem_req_valid && (vcnt >= cur_stall);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt          <= 0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      for (int i = 0; i < 128; i++) bmem[i] <= 16'hC000 + 16'(i);
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        vcnt <= 0;
        if (mem_req_we) bmem[{mem_req_sel, mem_req_addr[5:0]}] <= mem_req_wdata;
        else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= bmem[{mem_req_sel, mem_req_addr[5:0]}];
        end
      end else if (mem_req_valid) vcnt <= vcnt + 1;
    end
  end

  // ---- behavioural reference model ----
  bit          m_a1, m_a2, m_a2d, m_busy, m_rdy, m_read;
  int          m_lc, m_cnt, m_tgt, m_idx;
  logic [15:0] m_rdata;
  logic [15:0] m_regs [8];

  function automatic bit pin_act();
    if (bus_mode) return !cs_n && !strb_rd_n;
    return !cs_n && (!strb_rd_n || !dir_wr_n);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a1 = 0; m_a2 = 0; m_a2d = 0; m_busy = 0; m_rdy = 0; m_read = 0;
      m_lc = 0; m_cnt = 0; m_tgt = 1; m_idx = 0; m_rdata = '0;
      for (int i = 0; i < 8; i++) m_regs[i] = 16'h5A00 + 16'(i);
    end else begin
      bit lk;
      lk = (m_lc < LOCK);
      if (m_rdy) begin
        if (!m_a2) begin m_rdy = 0; m_busy = 0; end
      end else if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_rdy = 1;
          if (m_read) begin
            if (m_tgt == 0)      m_rdata = m_regs[m_idx];
            else if (m_tgt == 1) m_rdata = '0;
            else                 m_rdata = bmem[{m_tgt == 3, m_idx[5:0]}];
          end
        end
      end else if (!m_busy && m_a2 && !m_a2d && !lk) begin
        m_busy = 1;
        m_read = dir_wr_n;
        m_idx  = int'(addr[11:0]);
        case (addr[13:12])
          2'b00:   m_tgt = (m_idx < 8) ? 0 : 1;
          2'b01:   m_tgt = 1;
          2'b10:   m_tgt = 2;
          default: m_tgt = 3;
        endcase
        if (m_tgt < 2) m_cnt = 1;
        else           m_cnt = m_read ? 3 + cur_stall : 2 + cur_stall;
        if (m_tgt == 0 && !m_read) m_regs[m_idx] = wdata;
      end
      m_a2d = m_a2;
      m_a2  = m_a1;
      m_a1  = pin_act();
      if (lk) m_lc++;
    end
  end

  // ---- per-cycle comparison, away from the active edge ----
  always @(negedge clk) begin
    chk(data_rdy === m_rdy, "R3/R4/R8 data_rdy vs model", 32'(data_rdy), 32'(m_rdy));
    if (m_rdy && m_read)
      chk(rdata === m_rdata, "R6/R7/R10 rdata vs model", 32'(rdata), 32'(m_rdata));
    if (rst_n && mem_req_valid && mem_req_ready) begin
      chk(mem_req_sel === cur_addr[12], "R5 mem_req_sel", 32'(mem_req_sel), 32'(cur_addr[12]));
      chk(mem_req_addr === cur_addr[11:0], "R5 mem_req_addr", 32'(mem_req_addr), 32'(cur_addr[11:0]));
      chk(mem_req_we === cur_we, "R9 mem_req_we", 32'(mem_req_we), 32'(cur_we));
      if (cur_we)
        chk(mem_req_wdata === cur_wdata, "R9 mem_req_wdata", 32'(mem_req_wdata), 32'(cur_wdata));
    end
  end

  // ---- host access driver ----
  task automatic do_acc(input bit md, input logic [13:0] a, input bit w, input logic [15:0] d,
                        input int stall, input bit exp_ack, input int hold,
                        input logic [15:0] exp_rd, input string tag);
    bit seen;
    @(negedge clk);
    bus_mode  = md;
    addr      = a;
    wdata     = d;
    cur_addr  = a;
    cur_we    = w;
    cur_wdata = d;
    cur_stall = stall;
    if (md) dir_wr_n = !w;
    @(negedge clk);
    cs_n = 1'b0;
    if (md)     strb_rd_n = 1'b0;
    else if (w) dir_wr_n  = 1'b0;
    else        strb_rd_n = 1'b0;
    seen = 0;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (data_rdy) begin seen = 1; break; end
    end
    chk(seen == exp_ack, {tag, " acknowledge"}, 32'(seen), 32'(exp_ack));
    if (seen && !w) chk(rdata === exp_rd, {tag, " read word"}, 32'(rdata), 32'(exp_rd));
    repeat (2) @(negedge clk);
    cs_n = 1'b1; strb_rd_n = 1'b1; dir_wr_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(data_rdy === 1'b0, {tag, " R4 released"}, 32'(data_rdy), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; bus_mode = 1'b1; cs_n = 1'b1; strb_rd_n = 1'b1; dir_wr_n = 1'b1;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk(data_rdy === 1'b0, "R11 reset state", 32'(data_rdy), 32'd0);
    rst_n = 1'b1;

    do_acc(1, 14'h0000, 0, 16'h0, 0, 0, 12, 16'h0, "R8 inside lockout");
    do_acc(1, 14'h0001, 0, 16'h0, 0, 0, 50, 16'h0, "R8 strobe across lockout end");

    for (int i = 0; i < 8; i++)
      do_acc(1, 14'(i), 0, 16'h0, 0, 1, 40, 16'h5A00 + 16'(i), "R7 R3 default");

    do_acc(1, 14'h0003, 1, 16'h1234, 0, 1, 40, 16'h0,    "R1 write");
    do_acc(1, 14'h0003, 0, 16'h0,    0, 1, 40, 16'h1234, "R1 R7 read back");
    do_acc(0, 14'h0005, 1, 16'hBEEF, 0, 1, 40, 16'h0,    "R2 write");
    do_acc(0, 14'h0005, 0, 16'h0,    0, 1, 40, 16'hBEEF, "R2 read back");
    do_acc(1, 14'h0005, 0, 16'h0,    0, 1, 40, 16'hBEEF, "R1 R2 cross-mode read");

    do_acc(1, 14'h0008, 0, 16'h0,    0, 1, 40, 16'h0,    "R6 index past bank");
    do_acc(1, 14'h0008, 1, 16'h7777, 0, 1, 40, 16'h0,    "R6 write hole");
    do_acc(1, 14'h0008, 0, 16'h0,    0, 1, 40, 16'h0,    "R6 hole still zero");
    do_acc(1, 14'h1005, 1, 16'h6666, 0, 1, 40, 16'h0,    "R6 write region 01");
    do_acc(1, 14'h1005, 0, 16'h0,    0, 1, 40, 16'h0,    "R6 read region 01");
    do_acc(1, 14'h0005, 0, 16'h0,    0, 1, 40, 16'hBEEF, "R6 bank untouched");

    do_acc(1, 14'h2010, 1, 16'hA1A1, 0, 1, 40, 16'h0,    "R9 R5 conn write");
    do_acc(1, 14'h3010, 1, 16'hB2B2, 3, 1, 40, 16'h0,    "R9 stalled dmem write");
    do_acc(1, 14'h2010, 0, 16'h0,    2, 1, 40, 16'hA1A1, "R5 R10 conn read");
    do_acc(1, 14'h3010, 0, 16'h0,    0, 1, 40, 16'hB2B2, "R5 R10 dmem read");
    do_acc(0, 14'h2011, 0, 16'h0,    1, 1, 40, 16'hC011, "R2 R10 preset word");
    do_acc(0, 14'h3020, 1, 16'h5151, 4, 1, 40, 16'h0,    "R2 R9 dmem write");
    do_acc(0, 14'h3020, 0, 16'h0,    0, 1, 40, 16'h5151, "R2 R10 dmem read");

    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(data_rdy === 1'b0, "R11 mid-run reset", 32'(data_rdy), 32'd0);
    rst_n = 1'b1;
    do_acc(1, 14'h0003, 0, 16'h0, 0, 0, 10, 16'h0, "R11 lockout restarts");
    repeat (50) @(negedge clk);
    do_acc(1, 14'h0003, 0, 16'h0, 0, 1, 40, 16'h5A03, "R11 default reloaded");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule